// File: doc/BRIEF.md
# Vector Prefix Byte-Stream Decoder

This block sits in an instruction fetch path. It takes instruction bytes one per cycle and splits off the encoding prefix that comes before each opcode. It recognises three kinds of prefix. The first is the compact vector prefix in its two-byte form, which starts with 0xC5. The second is the same prefix in its three-byte form, which starts with 0xC4. The third is the single-byte register-extension prefix, which exists only in 64-bit operation.

For each instruction the block produces one record. The record carries the register-extension bits (R, X, B) and the W bit, written in true polarity. It also carries the extra source register index, the vector length, the implied legacy prefix byte, the opcode map, and the opcode and ModRM bytes. A flag tells whether a SIB byte follows the ModRM byte, and a second flag marks a reserved map value. Every instruction is taken to have exactly one opcode byte followed by one ModRM byte. The remaining legacy prefixes, displacements and immediates belong to later stages.

The 0xC4 and 0xC5 bytes are also the opcodes of the legacy segment-load instructions. In 32-bit operation the decoder therefore looks at the byte after the lead byte. If that byte does not have both top bits set, it is the ModRM byte of a segment-load instruction, and the pair is passed through as a plain opcode.

Both byte streams use valid/ready. An input byte is taken on a clock edge where `in_valid` and `in_ready` are both high. A record is handed over on an edge where `out_valid` and `out_ready` are both high. While a record waits to be taken, the decoder holds `in_ready` low and keeps every record field stable. Producers may therefore leave a byte waiting on `in_data` for as long as needed. The `mode64` input is sampled with the first byte of each instruction, and that value governs the whole instruction.

Top module: `vpfx_decoder`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1, and the block waits for the first byte of an instruction.
- R2: `out_valid` rises on the cycle after the ModRM byte is accepted. While `out_valid` is 1, `in_ready` is 0, no byte is consumed and the record is stable. `out_valid` falls on the cycle after an edge where `out_ready` is 1.
- R3: A first byte that is not a prefix is the opcode, and the next byte is the ModRM byte. The record then has `out_kind`=0 (legacy), `out_map`=0, `out_pfx`=0x00, and R, X, B, W and the source index all 0.
- R4: In 32-bit mode (`mode64`=0), a 0xC4 or 0xC5 byte followed by a byte whose bits [7:6] are not 11 gives a legacy record. Its opcode is the lead byte, its ModRM is the following byte, and no further byte is consumed.
- R5: The two-byte form (0xC5) gives `out_kind`=2. Its second byte holds ~R in bit 7, the inverted source index in bits [6:3], L in bit 2 and the pp field in bits [1:0]. The record has `out_map`=1, X=B=W=0 and `out_map_err`=0.
- R6: The three-byte form (0xC4) gives `out_kind`=3. Its second byte holds ~R in bit 7, ~X in bit 6, ~B in bit 5 and the map field in bits [4:0]. Its third byte holds W in bit 7, the inverted source index in bits [6:3], L in bit 2 and pp in bits [1:0].
- R7: A map field value of 1, 2 or 3 gives `out_map` of 1 (0x0F), 2 (0x0F 0x38) or 3 (0x0F 0x3A). Any other map value gives `out_map`=0 and `out_map_err`=1, while the opcode and ModRM bytes are still captured.
- R8: pp values 0, 1, 2 and 3 give `out_pfx` values of 0x00, 0x66, 0xF3 and 0xF2. `out_vlen` equals L, where 0 means 128-bit and 1 means 256-bit.
- R9: In 32-bit mode, `out_rex_r`, `out_rex_x`, `out_rex_b` and `out_vsrc[3]` are forced to 0.
- R10: In 64-bit mode, a first byte in 0x40 to 0x4F is a register-extension prefix with `out_kind`=1. Its bits give W=bit 3, R=bit 2, X=bit 1 and B=bit 0, with no inversion. In 32-bit mode such a byte is a plain opcode.
- R11: `out_sib` is 1 exactly when the ModRM bits [2:0] are 100 and bits [7:6] are not 11.
- R12: In 64-bit mode, 0xC4 and 0xC5 always start a prefix, whatever the next byte holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode64 | input | 1 | 1 = 64-bit operation, 0 = 32-bit; sampled with the first byte of each instruction |
| in_valid | input | 1 | Input byte is present |
| in_data | input | 8 | Instruction byte |
| in_ready | output | 1 | Decoder can take a byte |
| out_valid | output | 1 | Record is present |
| out_ready | input | 1 | Consumer takes the record |
| out_kind | output | 2 | 0 legacy, 1 register-extension, 2 two-byte vector, 3 three-byte vector |
| out_rex_r | output | 1 | Decoded R bit (true polarity) |
| out_rex_x | output | 1 | Decoded X bit |
| out_rex_b | output | 1 | Decoded B bit |
| out_w | output | 1 | W bit |
| out_vsrc | output | 4 | Extra source register index (true polarity) |
| out_vlen | output | 1 | Vector length: 0 = 128-bit, 1 = 256-bit |
| out_pfx | output | 8 | Implied legacy prefix byte (0x00 when there is none) |
| out_map | output | 2 | Opcode map: 0 none, 1 0x0F, 2 0x0F 0x38, 3 0x0F 0x3A |
| out_map_err | output | 1 | Reserved map field value |
| out_opcode | output | 8 | Opcode byte |
| out_modrm | output | 8 | ModRM byte |
| out_sib | output | 1 | A SIB byte follows the ModRM byte |

## Verification
A record is due exactly one cycle after the edge that accepts its ModRM byte. For a 32-bit segment-load pair, that is the edge that accepts the byte after the lead byte. When `out_ready` is high, the record must be gone one cycle later. Each bench task drives a byte for exactly one edge, samples one time unit after the edge that should have loaded the record, and samples again one edge later to see it leave. The back-pressure task holds `out_ready` low for several edges while a byte is offered. It checks that the record stays put, and then shows through the next record that the offered byte was never consumed.

// File: rtl/vpfx_pkg.sv
package vpfx_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_W  = 4;
  localparam int MAPF_W = 5;

  localparam logic [BYTE_W-1:0] LEAD_LONG  = 8'hC4;
  localparam logic [BYTE_W-1:0] LEAD_SHORT = 8'hC5;
  localparam logic [3:0]        REXT_HI    = 4'h4;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {
    K_LEGACY = 2'd0,
    K_REXT   = 2'd1,
    K_VSHORT = 2'd2,
    K_VLONG  = 2'd3
  } kind_t;

  typedef enum logic [1:0] {
    MAP_NONE = 2'd0,
    MAP_0F   = 2'd1,
    MAP_0F38 = 2'd2,
    MAP_0F3A = 2'd3
  } map_t;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_LEAD  = 3'd1,
    S_PB2   = 3'd2,
    S_OPC   = 3'd3,
    S_MODRM = 3'd4,
    S_EMIT  = 3'd5
  } st_t;

  typedef struct packed {
    logic             r;
    logic             x;
    logic             b;
    logic             w;
    logic [REG_W-1:0] vsrc;
    logic             vlen;
    byte_t            pfx;
    map_t             map;
    logic             map_err;
  } fields_t;

  function automatic logic is_lead(input byte_t v);
    return (v == LEAD_LONG) || (v == LEAD_SHORT);
  endfunction

  function automatic logic is_rext_hi(input logic [3:0] hi);
    return hi == REXT_HI;
  endfunction

  function automatic byte_t pp_to_byte(input logic [1:0] pp);
    case (pp)
      2'd1:    return 8'h66;
      2'd2:    return 8'hF3;
      2'd3:    return 8'hF2;
      default: return 8'h00;
    endcase
  endfunction

  function automatic map_t mapf_decode(input logic [MAPF_W-1:0] m);
    case (m)
      5'd1:    return MAP_0F;
      5'd2:    return MAP_0F38;
      5'd3:    return MAP_0F3A;
      default: return MAP_NONE;
    endcase
  endfunction
endpackage

// File: rtl/vpfx_seq.sv
module vpfx_seq
  import vpfx_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  mode64,
  input  logic  in_valid,
  input  byte_t in_data,
  output logic  in_ready,
  output logic  out_valid,
  input  logic  out_ready,
  output kind_t kind_q,
  output byte_t pb1_q,
  output byte_t pb2_q,
  output byte_t opc_q,
  output byte_t modrm_q,
  output logic  mode_q
);
  st_t   st_q;
  byte_t lead_q;
  logic  take;

  assign in_ready  = (st_q != S_EMIT);
  assign out_valid = (st_q == S_EMIT);
  assign take      = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= S_IDLE;
      kind_q  <= K_LEGACY;
      lead_q  <= '0;
      pb1_q   <= '0;
      pb2_q   <= '0;
      opc_q   <= '0;
      modrm_q <= '0;
      mode_q  <= 1'b0;
    end else if (take) begin
      case (st_q)
        S_IDLE: begin
          mode_q <= mode64;
          pb1_q  <= '0;
          pb2_q  <= '0;
          if (is_lead(in_data)) begin
            lead_q <= in_data;
            st_q   <= S_LEAD;
          end else if (mode64 && is_rext_hi(in_data[7:4])) begin
            kind_q <= K_REXT;
            pb1_q  <= in_data;
            st_q   <= S_OPC;
          end else begin
            kind_q <= K_LEGACY;
            opc_q  <= in_data;
            st_q   <= S_MODRM;
          end
        end
        S_LEAD: begin
          if (!mode_q && (in_data[7:6] != 2'b11)) begin
            // segment-load opcode: this byte is already its ModRM
            kind_q  <= K_LEGACY;
            opc_q   <= lead_q;
            modrm_q <= in_data;
            st_q    <= S_EMIT;
          end else begin
            pb1_q <= in_data;
            if (lead_q == LEAD_SHORT) begin
              kind_q <= K_VSHORT;
              st_q   <= S_OPC;
            end else begin
              kind_q <= K_VLONG;
              st_q   <= S_PB2;
            end
          end
        end
        S_PB2: begin
          pb2_q <= in_data;
          st_q  <= S_OPC;
        end
        S_OPC: begin
          opc_q <= in_data;
          st_q  <= S_MODRM;
        end
        S_MODRM: begin
          modrm_q <= in_data;
          st_q    <= S_EMIT;
        end
        default: st_q <= S_IDLE;
      endcase
    end else if ((st_q == S_EMIT) && out_ready) begin
      st_q <= S_IDLE;
    end
  end
endmodule

// File: rtl/vpfx_unpack.sv
module vpfx_unpack
  import vpfx_pkg::*;
(
  input  kind_t   kind,
  input  byte_t   pb1,
  input  byte_t   pb2,
  input  logic    mode_q,
  output fields_t fld
);
  fields_t          raw;
  logic [REG_W-1:0] vraw;
  logic [REG_W-1:0] vgate;

  always_comb begin
    raw  = '0;
    vraw = '0;
    case (kind)
      K_REXT: begin
        raw.w = pb1[3];
        raw.r = pb1[2];
        raw.x = pb1[1];
        raw.b = pb1[0];
      end
      K_VSHORT: begin
        raw.r    = ~pb1[7];
        vraw     = ~pb1[6:3];
        raw.vlen = pb1[2];
        raw.pfx  = pp_to_byte(pb1[1:0]);
        raw.map  = MAP_0F;
      end
      K_VLONG: begin
        raw.r       = ~pb1[7];
        raw.x       = ~pb1[6];
        raw.b       = ~pb1[5];
        raw.map     = mapf_decode(pb1[4:0]);
        raw.map_err = (mapf_decode(pb1[4:0]) == MAP_NONE);
        raw.w       = pb2[7];
        vraw        = ~pb2[6:3];
        raw.vlen    = pb2[2];
        raw.pfx     = pp_to_byte(pb2[1:0]);
      end
      default: raw = '0;
    endcase
  end

  // only the top index bit depends on the operating mode
  for (genvar i = 0; i < REG_W; i++) begin : g_vbit
    if (i == REG_W - 1) begin : g_hi
      assign vgate[i] = vraw[i] & mode_q;
    end else begin : g_lo
      assign vgate[i] = vraw[i];
    end
  end

  always_comb begin
    fld      = raw;
    fld.r    = raw.r & mode_q;
    fld.x    = raw.x & mode_q;
    fld.b    = raw.b & mode_q;
    fld.vsrc = vgate;
  end
endmodule

// File: rtl/vpfx_decoder.sv
module vpfx_decoder
  import vpfx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mode64,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [1:0] out_kind,
  output logic       out_rex_r,
  output logic       out_rex_x,
  output logic       out_rex_b,
  output logic       out_w,
  output logic [3:0] out_vsrc,
  output logic       out_vlen,
  output logic [7:0] out_pfx,
  output logic [1:0] out_map,
  output logic       out_map_err,
  output logic [7:0] out_opcode,
  output logic [7:0] out_modrm,
  output logic       out_sib
);
  kind_t   kind_q;
  byte_t   pb1_q;
  byte_t   pb2_q;
  byte_t   opc_q;
  byte_t   modrm_q;
  logic    mode_q;
  fields_t fld;

  vpfx_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .mode64    (mode64),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .kind_q    (kind_q),
    .pb1_q     (pb1_q),
    .pb2_q     (pb2_q),
    .opc_q     (opc_q),
    .modrm_q   (modrm_q),
    .mode_q    (mode_q)
  );

  vpfx_unpack u_unpack (
    .kind   (kind_q),
    .pb1    (pb1_q),
    .pb2    (pb2_q),
    .mode_q (mode_q),
    .fld    (fld)
  );

  assign out_kind    = kind_q;
  assign out_rex_r   = fld.r;
  assign out_rex_x   = fld.x;
  assign out_rex_b   = fld.b;
  assign out_w       = fld.w;
  assign out_vsrc    = fld.vsrc;
  assign out_vlen    = fld.vlen;
  assign out_pfx     = fld.pfx;
  assign out_map     = fld.map;
  assign out_map_err = fld.map_err;
  assign out_opcode  = opc_q;
  assign out_modrm   = modrm_q;
  assign out_sib     = (modrm_q[2:0] == 3'b100) && (modrm_q[7:6] != 2'b11);
endmodule

// File: rtl/vpfx_decoder_chk.sv
module vpfx_decoder_chk (
  input logic       clk,
  input logic       rst,
  input logic       mode64,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [1:0] out_kind,
  input logic       out_rex_r,
  input logic       out_rex_x,
  input logic       out_rex_b,
  input logic       out_w,
  input logic       v_hi,
  input logic [7:0] out_pfx,
  input logic [1:0] out_map,
  input logic       out_map_err,
  input logic [7:0] out_opcode,
  input logic [7:0] out_modrm
);
  // the checker keeps its own record of the mode of the current instruction
  logic fresh_q;
  logic m_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fresh_q <= 1'b1;
      m_q     <= 1'b0;
    end else if (in_valid && in_ready && fresh_q) begin
      fresh_q <= 1'b0;
      m_q     <= mode64;
    end else if (out_valid && out_ready) begin
      fresh_q <= 1'b1;
    end
  end

  a_r2_no_take_while_full: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  a_r2_hold_record: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_opcode) &&
      $stable(out_modrm) && $stable(out_kind) && $stable(out_pfx));

  a_r2_single_beat: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready |=> !out_valid);

  a_r2_rise_after_byte: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  a_r9_low_bank_only: assert property (@(posedge clk) disable iff (rst)
    out_valid && !m_q |-> !out_rex_r && !out_rex_x && !out_rex_b && !v_hi);

  a_r5_short_fixed: assert property (@(posedge clk) disable iff (rst)
    out_valid && (out_kind == 2'd2) |->
      (out_map == 2'd1) && !out_rex_x && !out_rex_b && !out_w && !out_map_err);

  a_r7_err_long_only: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_map_err |-> (out_kind == 2'd3) && (out_map == 2'd0));

  a_r10_rext_needs_64: assert property (@(posedge clk) disable iff (rst)
    out_valid && (out_kind == 2'd1) |-> m_q);

  a_r3_legacy_clean: assert property (@(posedge clk) disable iff (rst)
    out_valid && (out_kind == 2'd0) |->
      (out_map == 2'd0) && (out_pfx == 8'h00) && !out_rex_r && !out_w);
endmodule

bind vpfx_decoder vpfx_decoder_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .mode64      (mode64),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_kind    (out_kind),
  .out_rex_r   (out_rex_r),
  .out_rex_x   (out_rex_x),
  .out_rex_b   (out_rex_b),
  .out_w       (out_w),
  .v_hi        (out_vsrc[3]),
  .out_pfx     (out_pfx),
  .out_map     (out_map),
  .out_map_err (out_map_err),
  .out_opcode  (out_opcode),
  .out_modrm   (out_modrm)
);

// File: tb/vpfx_decoder_bench.sv
`timescale 1ns/100ps
module vpfx_decoder_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       mode64;
  logic       in_valid;
  logic [7:0] in_data;
  logic       in_ready;
  logic       out_valid;
  logic       out_ready;
  logic [1:0] out_kind;
  logic       out_rex_r, out_rex_x, out_rex_b, out_w;
  logic [3:0] out_vsrc;
  logic       out_vlen;
  logic [7:0] out_pfx;
  logic [1:0] out_map;
  logic       out_map_err;
  logic [7:0] out_opcode, out_modrm;
  logic       out_sib;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  vpfx_decoder u_vpfx_decoder (
    .clk(clk), .rst(rst), .mode64(mode64), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_kind(out_kind), .out_rex_r(out_rex_r),
    .out_rex_x(out_rex_x), .out_rex_b(out_rex_b), .out_w(out_w),
    .out_vsrc(out_vsrc), .out_vlen(out_vlen), .out_pfx(out_pfx),
    .out_map(out_map), .out_map_err(out_map_err), .out_opcode(out_opcode),
    .out_modrm(out_modrm), .out_sib(out_sib)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  // one byte, held for exactly one edge (decoder is ready outside a record)
  task automatic send(input logic [7:0] b);
    in_data  = b;
    in_valid = 1'b1;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  // record is sampled 1 time unit after the edge that took its last byte
  task automatic expect_rec(input string req, input int kind, input int r,
                            input int x, input int b, input int w, input int v,
                            input int l, input int pfx, input int map,
                            input int err, input int opc, input int modrm,
                            input int sib);
    chk(req, "out_valid", int'(out_valid), 1);
    chk(req, "kind", int'(out_kind), kind);
    chk(req, "r", int'(out_rex_r), r);
    chk(req, "x", int'(out_rex_x), x);
    chk(req, "b", int'(out_rex_b), b);
    chk(req, "w", int'(out_w), w);
    chk(req, "vsrc", int'(out_vsrc), v);
    chk(req, "vlen", int'(out_vlen), l);
    chk(req, "pfx", int'(out_pfx), pfx);
    chk(req, "map", int'(out_map), map);
    chk(req, "map_err", int'(out_map_err), err);
    chk(req, "opcode", int'(out_opcode), opc);
    chk(req, "modrm", int'(out_modrm), modrm);
    chk(req, "sib", int'(out_sib), sib);
    @(posedge clk);
    #1;
    chk("R2", "valid after take", int'(out_valid), 0);
    chk("R2", "ready after take", int'(in_ready), 1);
  endtask

  task automatic t_reset();
    chk("R1", "out_valid in reset", int'(out_valid), 0);
    chk("R1", "in_ready in reset", int'(in_ready), 1);
    rst = 1'b0;
    @(posedge clk);
    #1;
    chk("R1", "out_valid after reset", int'(out_valid), 0);
    chk("R1", "in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_plain32();
    mode64 = 1'b0;
    send(8'h8B); send(8'h04);
    expect_rec("R3 R11", 0, 0, 0, 0, 0, 0, 0, 8'h00, 0, 0, 8'h8B, 8'h04, 1);
    send(8'h44); send(8'hC8);
    expect_rec("R10 plain 4x in 32", 0, 0, 0, 0, 0, 0, 0, 8'h00, 0, 0, 8'h44, 8'hC8, 0);
  endtask

  task automatic t_segload32();
    mode64 = 1'b0;
    send(8'hC5); send(8'h06);
    expect_rec("R4 C5", 0, 0, 0, 0, 0, 0, 0, 8'h00, 0, 0, 8'hC5, 8'h06, 0);
    send(8'hC4); send(8'h84);
    expect_rec("R4 C4", 0, 0, 0, 0, 0, 0, 0, 8'h00, 0, 0, 8'hC4, 8'h84, 1);
  endtask

  task automatic t_short64();
    mode64 = 1'b1;
    send(8'hC5); send(8'h55); send(8'h58); send(8'hC1);
    expect_rec("R5 R8 R12", 2, 1, 0, 0, 0, 5, 1, 8'h66, 1, 0, 8'h58, 8'hC1, 0);
  endtask

  task automatic t_long64();
    mode64 = 1'b1;
    send(8'hC4); send(8'hA2); send(8'h9B); send(8'h99); send(8'h44);
    expect_rec("R6 R7 R8 R11", 3, 0, 1, 0, 1, 12, 0, 8'hF2, 2, 0, 8'h99, 8'h44, 1);
    send(8'hC4); send(8'hE3); send(8'h7E); send(8'h0F); send(8'hC0);
    expect_rec("R7 R8 map3", 3, 0, 0, 0, 0, 0, 1, 8'hF3, 3, 0, 8'h0F, 8'hC0, 0);
  endtask

  task automatic t_reserved_map();
    mode64 = 1'b1;
    send(8'hC4); send(8'hE0); send(8'h78); send(8'h12); send(8'hC3);
    expect_rec("R7 map0", 3, 0, 0, 0, 0, 0, 0, 8'h00, 0, 1, 8'h12, 8'hC3, 0);
    send(8'hC4); send(8'h7F); send(8'hFC); send(8'h34); send(8'h25);
    expect_rec("R7 map31", 3, 1, 0, 0, 1, 0, 1, 8'h00, 0, 1, 8'h34, 8'h25, 0);
  endtask

  task automatic t_vec32();
    mode64 = 1'b0;
    send(8'hC4); send(8'hC1); send(8'h02); send(8'h59); send(8'hCA);
    expect_rec("R9 long", 3, 0, 0, 0, 0, 7, 0, 8'hF3, 1, 0, 8'h59, 8'hCA, 0);
    send(8'hC5); send(8'hC4); send(8'h10); send(8'h0C);
    expect_rec("R9 short", 2, 0, 0, 0, 0, 7, 1, 8'h00, 1, 0, 8'h10, 8'h0C, 1);
  endtask

  task automatic t_rext64();
    mode64 = 1'b1;
    send(8'h4D); send(8'h89); send(8'h1C);
    expect_rec("R10 R11", 1, 1, 0, 1, 1, 0, 0, 8'h00, 0, 0, 8'h89, 8'h1C, 1);
  endtask

  task automatic t_backpressure();
    mode64    = 1'b0;
    out_ready = 1'b0;
    send(8'h01); send(8'hD8);
    chk("R2", "valid under stall", int'(out_valid), 1);
    in_data  = 8'hC5;
    in_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      #1;
      chk("R2", "held valid", int'(out_valid), 1);
      chk("R2", "ready low", int'(in_ready), 0);
      chk("R2", "held opcode", int'(out_opcode), 8'h01);
      chk("R2", "held modrm", int'(out_modrm), 8'hD8);
    end
    in_valid  = 1'b0;
    out_ready = 1'b1;
    @(posedge clk);
    #1;
    chk("R2", "released", int'(out_valid), 0);
    send(8'h31); send(8'hC0);
    expect_rec("R2 offered byte unused", 0, 0, 0, 0, 0, 0, 0, 8'h00, 0, 0, 8'h31, 8'hC0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got hang expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst       = 1'b1;
    mode64    = 1'b0;
    in_valid  = 1'b0;
    in_data   = 8'h00;
    out_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_plain32();
    t_segload32();
    t_short64();
    t_long64();
    t_reserved_map();
    t_vec32();
    t_rext64();
    t_backpressure();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule